// File: doc/BRIEF.md
# Discharge Overcurrent and Short-Circuit Fault Qualifier

This block turns two sampled comparator results into latched protection faults. One comparator flags a moderate overcurrent during discharge, the other a short circuit. On every sample tick (nominally 32 kHz) each result feeds its own run-length counter. When a comparator has stayed asserted for the programmed number of consecutive ticks, the matching fault bit is latched. The discharge switch command drops and the alert line to the host rises.

Detection is live only while the mode input reports normal operation. Each fault keeps its own delay code in a small configuration register. The register takes its default codes at power-on reset and keeps any code the host writes until the next reset. Fault bits are sticky. The host removes them by writing ones to the clear input. The analog comparators, threshold generation and the host bus sit outside this block.

Top module: `dsc_fault_det`

## Requirements
- R1: After reset, both fault bits are 0, alert is 0 and dsg_on is 1.
- R2: The overcurrent fault bit (fault_stat bit 0) sets on the clock edge of the Nth consecutive qualifying tick with ocd_cmp high. N is the delay in ms times 32, and the code-to-delay map is: code 0 = 8 ms, 1 = 20, 2 = 40, 3 = 80, 4 = 160, 5 = 320, 6 = 640, 7 = 1280 ms.
- R3: The short-circuit fault bit (fault_stat bit 1) sets on the Nth consecutive qualifying tick with scd_cmp high. The code-to-count map is: code 0 = 2, 1 = 4, 2 = 7, 3 = 13 ticks.
- R4: A qualifying tick on which a comparator is low returns that channel's count to zero, so a full new run is needed.
- R5: Cycles with smp_tick low neither advance nor reset a count; comparator values on those cycles are ignored.
- R6: While mode_normal is low, no fault sets and both counts are held at zero.
- R7: Fault bits are sticky. Writing 1 to bit i of stat_clr clears fault bit i on the next edge. If a new detection arrives in the same cycle as the clear, the bit stays set.
- R8: alert is 1 exactly when any fault bit is set, and dsg_on is then 0.
- R9: At reset the delay codes default to OCD code 0 and SCD code 0. A write with cfg_we replaces them, and the values are kept across mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| smp_tick | input | 1 | One-cycle sample enable |
| mode_normal | input | 1 | High while the device is in normal mode |
| ocd_cmp | input | 1 | Overcurrent comparator result |
| scd_cmp | input | 1 | Short-circuit comparator result |
| cfg_we | input | 1 | Load both delay codes |
| cfg_ocd_code | input | 3 | Overcurrent delay code |
| cfg_scd_code | input | 2 | Short-circuit delay code |
| stat_clr | input | 2 | Write-one-to-clear for fault bits (bit 0 OCD, bit 1 SCD) |
| fault_stat | output | 2 | Latched faults (bit 0 OCD, bit 1 SCD) |
| dsg_on | output | 1 | Discharge switch enable, low on any fault |
| alert | output | 1 | Host interrupt, high on any fault |

## Verification
The bench sweeps every delay code of both channels and counts the ticks until the fault appears. An off-by-one counter would show up as N-1 or N+1, and a wrong table entry as a different count. A run broken by one low tick, or by one cycle out of normal mode, must restart the full delay. A design that only paused the count there would fault early. Gaps between ticks must not count, so a design that counted every clock would fault too soon. A clear that lands on the same edge as a new detection must leave the bit set, so a clear-first design would lose that fault. Random runs compare every output on every cycle against a reference model.

// File: rtl/dfd_pkg.sv
package dfd_pkg;
   localparam int OCD_CW = 3;
   localparam int SCD_CW = 2;
   localparam int NCH    = 2;
   localparam int CH_OCD = 0;
   localparam int CH_SCD = 1;
   localparam int OCD_MAX_MS = 1280;

   // overcurrent delay in milliseconds per code
   function automatic int unsigned ocd_ms(input logic [OCD_CW-1:0] c);
      case (c)
         3'd0:    return 8;
         3'd1:    return 20;
         3'd2:    return 40;
         3'd3:    return 80;
         3'd4:    return 160;
         3'd5:    return 320;
         3'd6:    return 640;
         default: return OCD_MAX_MS;
      endcase
   endfunction

   // short-circuit delay in sample ticks per code
   function automatic int unsigned scd_ticks(input logic [SCD_CW-1:0] c);
      case (c)
         2'd0:    return 2;
         2'd1:    return 4;
         2'd2:    return 7;
         default: return 13;
      endcase
   endfunction
endpackage

// File: rtl/dfd_cfg_reg.sv
module dfd_cfg_reg
   import dfd_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int TICKS_PER_MS = 32,
   parameter int OCD_DEF      = 0,
   parameter int SCD_DEF      = 0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [OCD_CW-1:0]              ocd_in,
   input  logic [SCD_CW-1:0]              scd_in,
   output logic [NCH-1:0][CNT_W-1:0]      tgt
);
   logic [OCD_CW-1:0] ocd_q;
   logic [SCD_CW-1:0] scd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ocd_q <= OCD_CW'(OCD_DEF);
         scd_q <= SCD_CW'(SCD_DEF);
      end else if (we) begin
         ocd_q <= ocd_in;
         scd_q <= scd_in;
      end
   end

   always_comb begin
      tgt[CH_OCD] = CNT_W'(ocd_ms(ocd_q) * TICKS_PER_MS);
      tgt[CH_SCD] = CNT_W'(scd_ticks(scd_q));
   end
endmodule

// File: rtl/dfd_debounce.sv
module dfd_debounce #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             cmp,
   input  logic [CNT_W-1:0] tgt,
   output logic             hit
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt_q} + 1'b1;
   assign hit     = run && tick && cmp && (cnt_inc >= {1'b0, tgt});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= (cmp && !hit) ? cnt_inc[CNT_W-1:0] : '0;
   end
endmodule

// File: rtl/dfd_fault_latch.sv
module dfd_fault_latch #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] stat
);
   // a detection in the same cycle as a clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat <= '0;
      else
         stat <= (stat & ~clr) | set;
   end
endmodule

// File: rtl/dsc_fault_det.sv
module dsc_fault_det
   import dfd_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int TICKS_PER_MS = 32,
   parameter int OCD_DEF      = 0,
   parameter int SCD_DEF      = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_tick,
   input  logic              mode_normal,
   input  logic              ocd_cmp,
   input  logic              scd_cmp,
   input  logic              cfg_we,
   input  logic [OCD_CW-1:0] cfg_ocd_code,
   input  logic [SCD_CW-1:0] cfg_scd_code,
   input  logic [NCH-1:0]    stat_clr,
   output logic [NCH-1:0]    fault_stat,
   output logic              dsg_on,
   output logic              alert
);
   localparam longint MAX_TGT = longint'(OCD_MAX_MS) * TICKS_PER_MS;

   generate
      if (TICKS_PER_MS < 1)
         $error("TICKS_PER_MS must be positive");
      if (MAX_TGT >= (longint'(1) << CNT_W))
         $error("CNT_W too narrow for the longest delay");
      if (OCD_DEF < 0 || OCD_DEF >= (1 << OCD_CW) || SCD_DEF < 0 || SCD_DEF >= (1 << SCD_CW))
         $error("default delay code out of range");
   endgenerate

   logic [NCH-1:0][CNT_W-1:0] tgt;
   logic [NCH-1:0]            cmp_v;
   logic [NCH-1:0]            hit;

   assign cmp_v[CH_OCD] = ocd_cmp;
   assign cmp_v[CH_SCD] = scd_cmp;

   dfd_cfg_reg #(
      .CNT_W(CNT_W), .TICKS_PER_MS(TICKS_PER_MS),
      .OCD_DEF(OCD_DEF), .SCD_DEF(SCD_DEF)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we),
      .ocd_in(cfg_ocd_code), .scd_in(cfg_scd_code), .tgt(tgt)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      dfd_debounce #(.CNT_W(CNT_W)) u_dbc (
         .clk(clk), .rst_n(rst_n), .run(mode_normal), .tick(smp_tick),
         .cmp(cmp_v[g]), .tgt(tgt[g]), .hit(hit[g])
      );
   end

   dfd_fault_latch #(.N(NCH)) u_lat (
      .clk(clk), .rst_n(rst_n), .set(hit), .clr(stat_clr), .stat(fault_stat)
   );

   assign alert  = |fault_stat;
   assign dsg_on = ~|fault_stat;
endmodule

// File: rtl/dfd_checker.sv
module dfd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       smp_tick,
   input logic       mode_normal,
   input logic       ocd_cmp,
   input logic       scd_cmp,
   input logic [1:0] stat_clr,
   input logic [1:0] fault_stat,
   input logic       dsg_on,
   input logic       alert
);
   // R5 R6: OCD bit can only rise on a normal-mode tick with the comparator high
   p_ocd_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_stat[0] && !(smp_tick && mode_normal && ocd_cmp)) |=> !fault_stat[0]);
   p_scd_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_stat[1] && !(smp_tick && mode_normal && scd_cmp)) |=> !fault_stat[1]);
   p_sticky_ocd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_stat[0] && !stat_clr[0]) |=> fault_stat[0]);
   p_sticky_scd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_stat[1] && !stat_clr[1]) |=> fault_stat[1]);
   p_clear_ocd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr[0] && !ocd_cmp) |=> !fault_stat[0]);
   p_no_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_normal && fault_stat == 2'b00) |=> fault_stat == 2'b00);
   p_alert_dsg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      alert != dsg_on);
endmodule

bind dsc_fault_det dfd_checker u_chk (
   .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .mode_normal(mode_normal),
   .ocd_cmp(ocd_cmp), .scd_cmp(scd_cmp), .stat_clr(stat_clr),
   .fault_stat(fault_stat), .dsg_on(dsg_on), .alert(alert)
);

// File: tb/sim_dsc_fault_det.sv
module sim_dsc_fault_det;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n, smp_tick, mode_normal, ocd_cmp, scd_cmp, cfg_we;
   logic [2:0] cfg_ocd_code;
   logic [1:0] cfg_scd_code, stat_clr;
   logic [1:0] fault_stat;
   logic       dsg_on, alert;

   dsc_fault_det u0 (
      .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .mode_normal(mode_normal),
      .ocd_cmp(ocd_cmp), .scd_cmp(scd_cmp), .cfg_we(cfg_we),
      .cfg_ocd_code(cfg_ocd_code), .cfg_scd_code(cfg_scd_code),
      .stat_clr(stat_clr), .fault_stat(fault_stat), .dsg_on(dsg_on), .alert(alert)
   );

   int n_chk = 0;
   int n_fail = 0;
   string req = "R1";

   // reference model state
   int unsigned m_cnt [2];
   logic [1:0]  m_stat;
   logic [2:0]  m_oc;
   logic [1:0]  m_sc;

   function automatic int unsigned exp_ocd(input logic [2:0] c);
      int unsigned ms [8] = '{8, 20, 40, 80, 160, 320, 640, 1280};
      return ms[c] * 32;
   endfunction

   function automatic int unsigned exp_scd(input logic [1:0] c);
      int unsigned t [4] = '{2, 4, 7, 13};
      return t[c];
   endfunction

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", r, what, act, exp, $time);
      end
   endtask

   task automatic cyc();
      logic [1:0] hit, cv;
      int unsigned tg [2];
      @(posedge clk);
      if (!rst_n) begin
         m_cnt[0] = 0; m_cnt[1] = 0; m_stat = 2'b00; m_oc = 3'd0; m_sc = 2'd0;
      end else begin
         tg[0] = exp_ocd(m_oc);
         tg[1] = exp_scd(m_sc);
         cv = {scd_cmp, ocd_cmp};
         for (int i = 0; i < 2; i++) begin
            hit[i] = mode_normal && smp_tick && cv[i] && (m_cnt[i] + 1 >= tg[i]);
            if (!mode_normal) m_cnt[i] = 0;
            else if (smp_tick) m_cnt[i] = (cv[i] && !hit[i]) ? m_cnt[i] + 1 : 0;
         end
         m_stat = (m_stat & ~stat_clr) | hit;
         if (cfg_we) begin m_oc = cfg_ocd_code; m_sc = cfg_scd_code; end
      end
      @(negedge clk);
      chk(req, {28'd0, fault_stat, alert, dsg_on}, {28'd0, m_stat, |m_stat, ~|m_stat}, "stat/alert/dsg");
   endtask

   task automatic quiet();
      smp_tick = 0; ocd_cmp = 0; scd_cmp = 0; stat_clr = 0; cfg_we = 0; mode_normal = 1;
   endtask

   task automatic clear_all();
      quiet(); stat_clr = 2'b11; cyc(); stat_clr = 2'b00;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      int n;
      void'($urandom(32'h5eed_0c0d));
      rst_n = 0; cfg_ocd_code = 0; cfg_scd_code = 0;
      quiet(); mode_normal = 0;
      @(negedge clk);
      repeat (3) cyc();
      rst_n = 1;
      // R1 reset state
      chk("R1", {30'd0, fault_stat}, 0, "fault_stat");
      chk("R1", {31'd0, alert}, 0, "alert");
      chk("R1", {31'd0, dsg_on}, 1, "dsg_on");

      // R9 default SCD delay is 2 ticks
      req = "R9"; mode_normal = 1; smp_tick = 1; scd_cmp = 1;
      cyc(); chk("R9", {31'd0, fault_stat[1]}, 0, "scd after 1 tick");
      cyc(); chk("R9", {31'd0, fault_stat[1]}, 1, "scd after 2 ticks");
      clear_all();

      // R3 sweep of short-circuit codes
      req = "R3";
      for (int c = 0; c < 4; c++) begin
         cfg_we = 1; cfg_scd_code = 2'(c); cfg_ocd_code = 0; cyc(); cfg_we = 0;
         smp_tick = 1; scd_cmp = 1; n = 0;
         while (!fault_stat[1] && n < 40) begin cyc(); n++; end
         chk("R3", n, exp_scd(2'(c)), "scd ticks to fault");
         clear_all();
      end

      // R2 sweep of overcurrent codes
      req = "R2";
      for (int c = 0; c < 8; c++) begin
         cfg_we = 1; cfg_ocd_code = 3'(c); cfg_scd_code = 0; cyc(); cfg_we = 0;
         smp_tick = 1; ocd_cmp = 1; n = 0;
         while (!fault_stat[0] && n < 41000) begin cyc(); n++; end
         chk("R2", n, exp_ocd(3'(c)), "ocd ticks to fault");
         chk("R8", {30'd0, alert, dsg_on}, 32'b10, "alert/dsg on ocd fault");
         clear_all();
      end

      // R4: one low tick restarts a 7-tick run
      req = "R4";
      cfg_we = 1; cfg_ocd_code = 0; cfg_scd_code = 2; cyc(); cfg_we = 0;
      smp_tick = 1; scd_cmp = 1; repeat (6) cyc();
      scd_cmp = 0; cyc();
      scd_cmp = 1; repeat (6) cyc();
      chk("R4", {31'd0, fault_stat[1]}, 0, "after broken run");
      cyc();
      chk("R4", {31'd0, fault_stat[1]}, 1, "after full run");
      clear_all();

      // R5: non-tick cycles do not count (code 0 = 2 ticks)
      req = "R5";
      cfg_we = 1; cfg_scd_code = 0; cyc(); cfg_we = 0;
      smp_tick = 0; scd_cmp = 1; repeat (10) cyc();
      chk("R5", {31'd0, fault_stat[1]}, 0, "no ticks");
      smp_tick = 1; cyc();
      smp_tick = 0; scd_cmp = 0; repeat (3) cyc();
      chk("R5", {31'd0, fault_stat[1]}, 0, "one tick only");
      scd_cmp = 1; smp_tick = 1; cyc();
      chk("R5", {31'd0, fault_stat[1]}, 1, "second tick across gap");
      clear_all();

      // R6: no detection outside normal mode; leaving normal resets counts
      req = "R6";
      mode_normal = 0; smp_tick = 1; scd_cmp = 1; ocd_cmp = 1; repeat (300) cyc();
      chk("R6", {30'd0, fault_stat}, 0, "out of normal mode");
      ocd_cmp = 0;
      cfg_we = 1; cfg_scd_code = 3; cyc(); cfg_we = 0;
      mode_normal = 1; repeat (10) cyc();
      mode_normal = 0; cyc();
      mode_normal = 1; repeat (12) cyc();
      chk("R6", {31'd0, fault_stat[1]}, 0, "count restarted after mode exit");
      cyc();
      chk("R9", {31'd0, fault_stat[1]}, 1, "code 3 kept across mode change");

      // R7: sticky, clear, set wins over clear
      req = "R7";
      scd_cmp = 0; smp_tick = 0; repeat (5) cyc();
      chk("R7", {31'd0, fault_stat[1]}, 1, "sticky without clear");
      cfg_we = 1; cfg_scd_code = 0; cyc(); cfg_we = 0;
      stat_clr = 2'b01; cyc(); stat_clr = 0;
      chk("R7", {31'd0, fault_stat[1]}, 1, "clear of other bit");
      clear_all();
      smp_tick = 1; scd_cmp = 1; cyc(); cyc();
      chk("R7", {31'd0, fault_stat[1]}, 1, "set");
      cyc();
      stat_clr = 2'b10; cyc(); stat_clr = 0;
      chk("R7", {31'd0, fault_stat[1]}, 1, "set wins over clear");
      scd_cmp = 0; smp_tick = 0; stat_clr = 2'b10; cyc(); stat_clr = 0;
      chk("R7", {31'd0, fault_stat[1]}, 0, "cleared");
      chk("R8", {30'd0, alert, dsg_on}, 32'b01, "alert low after clear");

      // random mix
      req = "R2 R3 R4 R5 R6 R7 R8 random";
      cfg_we = 1; cfg_ocd_code = 0; cfg_scd_code = 1; cyc(); cfg_we = 0;
      for (int k = 0; k < 40; k++) begin
         int len = 1 + int'($urandom_range(299));
         logic oc = ($urandom_range(3) != 0);
         for (int j = 0; j < len; j++) begin
            ocd_cmp     = oc;
            scd_cmp     = ($urandom_range(7) != 0);
            smp_tick    = ($urandom_range(1) != 0);
            mode_normal = ($urandom_range(31) != 0);
            stat_clr    = ($urandom_range(15) == 0) ? 2'($urandom_range(3)) : 2'b00;
            cfg_we      = ($urandom_range(63) == 0);
            cfg_scd_code = 2'($urandom_range(3));
            cfg_ocd_code = 3'd0;
            cyc();
         end
      end
      quiet();
      summary();
      $finish;
   end
endmodule